// File: doc/BRIEF.md
# Fractional Pixel Clock Generator

This block derives a display pixel clock from one of two input clock sources. Each source is modelled as a one-cycle enable on the system clock, and each enable pulse counts as one half of an input clock cycle. Running the counter on half-cycles lets the rising and falling edges of the output land on half-input-cycle boundaries, so even an odd integer ratio can give a 50% duty cycle. The divider has an integer part and a 4-bit fraction. A fraction accumulator lengthens a period by one whole input cycle whenever it overflows, so the average period matches a non-integer ratio.

Software programs the block through a write-only port that holds three words: the divider word, the edge word and the control word. The outputs are the pixel clock level and a single-cycle tick at the start of every pixel period, which downstream sync counters use as their advance strobe. A divider write restarts the period from zero so that the new ratio begins cleanly. Edge and control writes take effect without disturbing the running period.

Top module: `pclk_gen`

## Requirements
- R1: After reset, pix_clk and pix_tick are low. The registers hold divider 0x010 (divide by one), rise position 0, fall position 1, bus source and no inversion. In this state the output goes high on the first selected step and low on the second, and it keeps alternating after that.
- R2: The divider word (wr_sel=0) carries the integer ratio N in bits 11:4. With a zero fraction, every period lasts exactly 2·N selected steps.
- R3: An integer field of zero is treated as N=1.
- R4: The fraction F sits in bits 3:0 of the divider word. At each period start a 4-bit accumulator adds F, starting from zero after a divider write. A carry out adds 2 steps to that period. Sixteen consecutive periods therefore last 32·N+2·F steps in total.
- R5: The edge word (wr_sel=1) holds the rise position in bits 8:0 and the fall position in bits 24:16, both counted in steps from period start. The step at the rise position drives the output high and the step at the fall position drives it low. Fall wins when the two positions are equal, and a position beyond the period length is never reached.
- R6: Control bit 20 (wr_sel=2) selects ext_en when set and bus_en when clear. The unselected enable has no effect.
- R7: Control bit 17 inverts pix_clk. pix_tick is unaffected.
- R8: A divider write drives the output level low and clears pix_tick. The next selected step is position 0, and any enable in the write cycle is ignored.
- R9: pix_tick is high for exactly one cycle, in the cycle after the step at position 0, and never in two consecutive cycles.
- R10: Edge and control writes do not restart the period counter or the fraction accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en | input | 1 | Half-cycle enable of the external display clock source |
| bus_en | input | 1 | Half-cycle enable of the internal bus clock source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Word select: 0 divider, 1 edge, 2 control |
| wr_data | input | 32 | Write data |
| pix_clk | output | 1 | Pixel clock level |
| pix_tick | output | 1 | One-cycle strobe per pixel period |

## Verification
Random dividers with small integer parts and arbitrary fractions are run with sparse and dense enable patterns. A reference model tracks every step, which separates correct carry stretching from off-by-one period lengths. Random edge words include equal and out-of-range positions, which exercise the fall-over-rise priority and the unreachable-edge case. Directed runs cover several more corners: a zero integer field, sixteen-period totals, a disabled source under each select value, inversion, and edge writes in mid-period. Each of these distinguishes correct restart and no-restart behaviour from a counter that resets on every write.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
    localparam int DATA_W   = 32;
    localparam int INT_W    = 8;
    localparam int FRAC_W   = 4;
    localparam int EDGE_W   = 9;
    localparam int DIV_W    = INT_W + FRAC_W;
    localparam int POS_W    = INT_W + 2;
    localparam int FALL_LSB = 16;
    localparam int SRC_BIT  = 20;
    localparam int INV_BIT  = 17;
    localparam int USED_TOP = FALL_LSB + EDGE_W;

    localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(12'h010);

    typedef enum logic [1:0] {
        REG_DIV  = 2'd0,
        REG_EDGE = 2'd1,
        REG_CTRL = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [INT_W-1:0]  whole;
        logic [FRAC_W-1:0] frac;
    } div_t;

    typedef struct packed {
        logic [EDGE_W-1:0] rise;
        logic [EDGE_W-1:0] fall;
    } edge_t;

    typedef struct packed {
        logic ext_src;
        logic invert;
    } ctrl_t;

    function automatic div_t unpack_div(input logic [DATA_W-1:0] d);
        div_t r;
        r.whole = d[FRAC_W +: INT_W];
        r.frac  = d[0 +: FRAC_W];
        return r;
    endfunction

    function automatic edge_t unpack_edge(input logic [DATA_W-1:0] d);
        edge_t r;
        r.rise = d[0 +: EDGE_W];
        r.fall = d[FALL_LSB +: EDGE_W];
        return r;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] d);
        ctrl_t r;
        r.ext_src = d[SRC_BIT];
        r.invert  = d[INV_BIT];
        return r;
    endfunction

    function automatic logic [INT_W-1:0] eff_int(input logic [INT_W-1:0] w);
        return (w == '0) ? INT_W'(1) : w;
    endfunction

    function automatic logic [POS_W-1:0] period_len(input logic [INT_W-1:0] w,
                                                    input logic carry);
        logic [POS_W-1:0] base;
        base = POS_W'({eff_int(w), 1'b0});
        return carry ? base + POS_W'(2) : base;
    endfunction
endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
    import pclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output div_t              div_q,
    output div_t              div_new,
    output edge_t             edge_q,
    output ctrl_t             ctrl_q,
    output logic              restart
);
    logic unused_hi_bits;
    assign unused_hi_bits = ^wr_data[DATA_W-1:USED_TOP];

    assign div_new = unpack_div(wr_data);
    assign restart = wr_en && (wr_sel == REG_DIV);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= div_t'(DIV_RESET);
            edge_q <= '{rise: '0, fall: EDGE_W'(1)};
            ctrl_q <= '{ext_src: 1'b0, invert: 1'b0};
        end else if (wr_en) begin
            case (wr_sel)
                REG_DIV:  div_q  <= div_new;
                REG_EDGE: edge_q <= unpack_edge(wr_data);
                REG_CTRL: ctrl_q <= unpack_ctrl(wr_data);
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/pclk_src_sel.sv
module pclk_src_sel
    import pclk_pkg::*;
(
    input  logic  ext_en,
    input  logic  bus_en,
    input  ctrl_t ctrl,
    input  logic  restart,
    output logic  step
);
    // A restart cycle swallows any enable so the new period starts cleanly.
    always_comb begin
        step = ctrl.ext_src ? ext_en : bus_en;
        if (restart) step = 1'b0;
    end
endmodule

// File: rtl/pclk_frac_acc.sv
module pclk_frac_acc
    import pclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             wrap,
    input  div_t             div_cur,
    input  div_t             div_new,
    output logic [POS_W-1:0] len
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;

    assign sum = {1'b0, acc} + {1'b0, div_cur.frac};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            len <= period_len(DIV_RESET[FRAC_W +: INT_W], 1'b0);
        end else if (restart) begin
            acc <= div_new.frac;
            len <= period_len(div_new.whole, 1'b0);
        end else if (wrap) begin
            acc <= sum[FRAC_W-1:0];
            len <= period_len(div_cur.whole, sum[FRAC_W]);
        end
    end
endmodule

// File: rtl/pclk_edge_seq.sv
module pclk_edge_seq
    import pclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             restart,
    input  logic [POS_W-1:0] len,
    input  edge_t            edges,
    output logic             wrap,
    output logic [POS_W-1:0] pos,
    output logic             raw,
    output logic             tick
);
    logic hit_rise, hit_fall;

    assign hit_rise = (pos == POS_W'(edges.rise));
    assign hit_fall = (pos == POS_W'(edges.fall));
    assign wrap     = step && (pos == len - POS_W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pos  <= '0;
            raw  <= 1'b0;
            tick <= 1'b0;
        end else if (step) begin
            if (hit_fall)      raw <= 1'b0;
            else if (hit_rise) raw <= 1'b1;
            tick <= (pos == '0);
            pos  <= wrap ? '0 : pos + POS_W'(1);
        end else begin
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/pclk_gen.sv
module pclk_gen
    import pclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_en,
    input  logic              bus_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pix_clk,
    output logic              pix_tick
);
    div_t             div_q, div_new;
    edge_t            edge_q;
    ctrl_t            ctrl_q;
    logic             div_restart;
    logic             sel_step;
    logic             period_wrap;
    logic [POS_W-1:0] cur_len;
    logic [POS_W-1:0] cur_pos;
    logic             pix_raw;

    pclk_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .div_q(div_q), .div_new(div_new), .edge_q(edge_q), .ctrl_q(ctrl_q),
        .restart(div_restart)
    );

    pclk_src_sel u_src (
        .ext_en(ext_en), .bus_en(bus_en), .ctrl(ctrl_q),
        .restart(div_restart), .step(sel_step)
    );

    pclk_frac_acc u_acc (
        .clk(clk), .rst(rst), .restart(div_restart), .wrap(period_wrap),
        .div_cur(div_q), .div_new(div_new), .len(cur_len)
    );

    pclk_edge_seq u_seq (
        .clk(clk), .rst(rst), .step(sel_step), .restart(div_restart),
        .len(cur_len), .edges(edge_q), .wrap(period_wrap), .pos(cur_pos),
        .raw(pix_raw), .tick(pix_tick)
    );

    assign pix_clk = pix_raw ^ ctrl_q.invert;
endmodule

// File: rtl/pclk_gen_chk.sv
module pclk_gen_chk
    import pclk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pix_tick,
    input logic             raw,
    input logic             step,
    input logic             restart,
    input logic [POS_W-1:0] pos,
    input logic [POS_W-1:0] len
);
    p_tick_spacing_r9: assert property (@(posedge clk) disable iff (rst)
        pix_tick |=> !pix_tick);

    p_tick_from_step_r9: assert property (@(posedge clk) disable iff (rst)
        pix_tick |-> $past(step));

    p_restart_clears_r8: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!raw && !pix_tick && pos == '0));

    p_pos_in_period_r2: assert property (@(posedge clk) disable iff (rst)
        pos < len);

    p_len_shape_r4: assert property (@(posedge clk) disable iff (rst)
        (len[0] == 1'b0) && (len >= POS_W'(2)));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!step && !restart) |=> ($stable(raw) && $stable(pos)));
endmodule

bind pclk_gen pclk_gen_chk u_chk (
    .clk(clk), .rst(rst), .pix_tick(pix_tick), .raw(pix_raw),
    .step(sel_step), .restart(div_restart), .pos(cur_pos), .len(cur_len)
);

// File: tb/pclk_gen_test.sv
module pclk_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_en = 1'b0, bus_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        pix_clk, pix_tick;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference state
    int m_int, m_frac, m_rise, m_fall, m_ext, m_inv;
    int m_pos, m_len, m_acc, m_raw, m_tick;

    always #(CLK_PERIOD/2) clk = ~clk;

    pclk_gen uut (
        .clk(clk), .rst(rst), .ext_en(ext_en), .bus_en(bus_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pix_clk(pix_clk), .pix_tick(pix_tick)
    );

    function automatic int f_len(input int n, input int carry);
        int e;
        e = (n == 0) ? 1 : n;
        return 2 * e + (carry ? 2 : 0);
    endfunction

    task automatic model_reset();
        m_int = 1; m_frac = 0; m_rise = 0; m_fall = 1; m_ext = 0; m_inv = 0;
        m_pos = 0; m_len = 2; m_acc = 0; m_raw = 0; m_tick = 0;
    endtask

    task automatic model_step();
        int s;
        if (m_pos == m_fall)      m_raw = 0;
        else if (m_pos == m_rise) m_raw = 1;
        m_tick = (m_pos == 0);
        if (m_pos == m_len - 1) begin
            s = m_acc + m_frac;
            m_acc = s % 16;
            m_len = f_len(m_int, s >= 16);
            m_pos = 0;
        end else begin
            m_pos++;
        end
    endtask

    task automatic compare(input string tag);
        int exp_clk;
        exp_clk = m_raw ^ m_inv;
        checks++;
        if (pix_clk !== exp_clk[0] || pix_tick !== m_tick[0]) begin
            fails++;
            $display("FAIL %s: clk=%b tick=%b expected clk=%0d tick=%0d at %0t",
                     tag, pix_clk, pix_tick, exp_clk, m_tick, $time);
        end
    endtask

    task automatic cyc(input logic e, input logic b, input string tag);
        @(negedge clk);
        ext_en = e; bus_en = b; wr_en = 1'b0;
        @(posedge clk);
        if (m_ext ? e : b) model_step(); else m_tick = 0;
        #1 compare(tag);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d, input string tag);
        @(negedge clk);
        ext_en = 1'b0; bus_en = 1'b0; wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        m_tick = 0;
        case (sel)
            2'd0: begin
                m_int = d[11:4]; m_frac = d[3:0];
                m_pos = 0; m_acc = m_frac; m_len = f_len(m_int, 0); m_raw = 0;
            end
            2'd1: begin m_rise = d[8:0]; m_fall = d[24:16]; end
            2'd2: begin m_ext = d[20]; m_inv = d[17]; end
            default: ;
        endcase
        #1 compare(tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: expired expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int t_first, t_last, nticks, nsteps;
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1 compare("R1 reset");
        // R1: pass-through toggling at reset values
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, "R1 passthrough");

        // R2: integer ratio 3, 50% duty (fall = 3)
        wr(2'd1, {7'd0, 9'd3, 7'd0, 9'd0}, "R10 edge write");
        wr(2'd0, 32'h030, "R8 restart");
        for (int i = 0; i < 18; i++) cyc(1'b0, 1'b1, "R2 divide");

        // R3: zero integer field
        wr(2'd1, {7'd0, 9'd1, 7'd0, 9'd0}, "R5 edges");
        wr(2'd0, 32'h000, "R3 write");
        for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, "R3 zero as one");

        // R4: sixteen periods of N=2, F=5 total 74 steps
        wr(2'd0, 32'h025, "R8 restart");
        nticks = 0; nsteps = 0; t_first = 0; t_last = 0;
        while (nticks < 17 && nsteps < 400) begin
            cyc(1'b0, 1'b1, "R4 fraction");
            nsteps++;
            if (pix_tick) begin
                if (nticks == 0) t_first = nsteps;
                t_last = nsteps;
                nticks++;
            end
        end
        checks++;
        if (t_last - t_first != 74) begin
            fails++;
            $display("FAIL R4: sixteen periods=%0d expected 74", t_last - t_first);
        end

        // R5: fall wins on equal positions; unreachable rise
        wr(2'd0, 32'h040, "R8 restart");
        wr(2'd1, {7'd0, 9'd2, 7'd0, 9'd2}, "R5 equal");
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, "R5 fall priority");
        wr(2'd1, {7'd0, 9'd1, 7'd0, 9'd100}, "R5 far rise");
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, "R5 unreachable");

        // R6: external source selected, bus enable ignored
        wr(2'd1, {7'd0, 9'd4, 7'd0, 9'd1}, "R5 edges");
        wr(2'd2, 32'h0010_0000, "R6 select ext");
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, "R6 ext steps");
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, "R6 bus ignored");
        wr(2'd2, 32'h0000_0000, "R6 select bus");
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, "R6 ext ignored");

        // R7: inversion
        wr(2'd2, 32'h0002_0000, "R7 invert");
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, "R7 inverted");

        // R8: enable during restart write is swallowed
        @(negedge clk);
        bus_en = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h021;
        @(posedge clk);
        m_int = 2; m_frac = 1; m_pos = 0; m_acc = 1; m_len = 4; m_raw = 0; m_tick = 0;
        #1 compare("R8 swallowed step");
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, "R8 after restart");

        // R10: edge write mid-period keeps counter
        wr(2'd0, 32'h050, "R8 restart");
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, "R10 pre");
        wr(2'd1, {7'd0, 9'd7, 7'd0, 9'd4}, "R10 mid write");
        for (int i = 0; i < 14; i++) cyc(1'b0, 1'b1, "R10 continue");

        // random mix: R2 R4 R5 R9
        for (int k = 0; k < 60; k++) begin
            int sel;
            sel = $urandom_range(0, 3);
            if (sel == 0) wr(2'd0, {20'd0, 8'($urandom_range(0, 5)), 4'($urandom)}, "R4 random div");
            else if (sel == 1) wr(2'd1, {7'd0, 9'($urandom_range(0, 12)), 7'd0, 9'($urandom_range(0, 12))}, "R5 random edge");
            else if (sel == 2) wr(2'd2, ($urandom & 32'h0012_0000), "R6 random ctrl");
            for (int i = 0; i < 40; i++)
                cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), "R9 random run");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule